// File: doc/BRIEF.md
# Paged Processor Register Port

This block connects an asynchronous 8-bit processor bus to the memories of a time-slot switch. The bus has an active-low chip select, an active-high data strobe, a read/write line (high means read) and six address lines. A transfer ends when the block pulls its active-low acknowledge low. The acknowledge stays low until the processor drops the strobe.

The bus sees only 64 locations. When the top address line is low, the access goes to an 8-bit control register. When it is high, the access goes to a 32-entry page, and the low five address lines pick the channel. The control register supplies the stream number and the memory that the page maps onto: the received-data memory, the low connection memory (an 8-bit source address or message byte per output channel) or the high connection memory (a few per-channel control bits). A split setting sends page reads to the received-data memory and page writes to the low connection memory, whatever memory the select field names. A global message bit is brought out to the serial side.

The two connection memories have a dedicated read port for the serial side, so processor accesses to them never wait. The received-data memory has one read port, and the serial fetch logic uses it. A processor read of that memory waits for a free slot signalled by the serial side, so its acknowledge comes much later. Strobe and chip select are synchronised into the system clock. Address, read/write and write data must be stable from before the strobe rises until the acknowledge goes high again.

Top module: `paged_cpu_port`

## Requirements
- R1: With `addr[5]`=0 the control register is accessed whatever `addr[4:0]` holds. Writes store `wdata` except bit 5, which always reads back 0.
- R2: With `addr[5]`=1 the page location is {control bits 2..0 as stream, `addr[4:0]` as channel}. Control bits 4..3 select the memory: 01 received-data memory, 10 low connection memory, 11 high connection memory.
- R3: The high connection memory stores bits 2..0 of the written byte. Processor reads return those bits with bits 7..3 zero.
- R4: Page writes to the received-data memory, and every page access with select 00, change no memory but are still acknowledged. Reads with select 00 return 0.
- R5: When control bit 7 is 1, page reads come from the received-data memory and page writes go to the low connection memory, ignoring bits 4..3. Rewriting the control register with bit 7 at 0 restores normal selection.
- R6: `msg_all` equals control register bit 6.
- R7: For control register and connection memory accesses, `dta_n` falls within 6 clocks of the strobe rising. It stays low while the strobe is held and rises within 4 clocks of the strobe falling.
- R8: A processor read of the received-data memory is not acknowledged while `dm_slot` is low. Once a slot is granted, it returns the byte the serial side last wrote to that location.
- R9: `ser_cm_low` and `ser_cm_high` present the connection memory contents at `ser_cm_addr` one clock after the address is applied.
- R10: After reset the control register is 0, `dta_n` is 1, `rdata_en` is 0 and `msg_all` is 0.
- R11: `rdata_en` is 1 only while a read is being acknowledged, and it is 0 during write acknowledges and after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ds | input | 1 | Data strobe, active high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Bus address |
| wdata | input | 8 | Write data from processor |
| rdata | output | 8 | Read data to processor |
| rdata_en | output | 1 | Read data valid (pad drive enable) |
| dta_n | output | 1 | Transfer acknowledge, active low |
| ser_dm_we | input | 1 | Serial side writes received-data memory |
| ser_dm_waddr | input | 8 | Received-data write location {stream, channel} |
| ser_dm_wdata | input | 8 | Received byte |
| ser_dm_raddr | input | 8 | Serial fetch location in received-data memory |
| ser_dm_q | output | 8 | Fetched byte, one clock after the address |
| dm_slot | input | 1 | Read port free for processor this clock |
| ser_cm_addr | input | 8 | Serial read location in connection memories |
| ser_cm_low | output | 8 | Low connection memory byte |
| ser_cm_high | output | 3 | High connection memory bits |
| msg_all | output | 1 | Global message setting (control bit 6) |

## Verification
The bench uses the default build: 8 streams of 32 channels and 3 high connection bits, so every memory has exactly 256 locations. This small size lets the bench write and read back every location of both connection memories through the paged bus, cross-check each one on the serial read port, and read all 256 received-data bytes through slot-granted reads. Expected contents come from arithmetic on the location index. With each memory covered in full, every value of the stream field and every channel address is exercised, together with split mode, the reserved select code and a held-off slot.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_DM   = 2'b01,
    SEL_CML  = 2'b10,
    SEL_CMH  = 2'b11
  } win_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DM_WAIT = 2'd1,
    ST_RD      = 2'd2,
    ST_ACK     = 2'd3
  } acc_state_e;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pp_sdp_ram.sv
module pp_sdp_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rq <= mem[raddr];
  end
endmodule

// File: rtl/pp_tdp_ram.sv
module pp_tdp_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/paged_cpu_port.sv
module paged_cpu_port #(
  parameter int STREAM_W = 3,
  parameter int CHAN_W   = 5,
  parameter int CMH_W    = 3,
  parameter int SYNC_STG = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cs_n,
  input  logic                          ds,
  input  logic                          rw,
  input  logic [CHAN_W:0]               addr,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    rdata,
  output logic                          rdata_en,
  output logic                          dta_n,
  input  logic                          ser_dm_we,
  input  logic [STREAM_W+CHAN_W-1:0]    ser_dm_waddr,
  input  logic [7:0]                    ser_dm_wdata,
  input  logic [STREAM_W+CHAN_W-1:0]    ser_dm_raddr,
  output logic [7:0]                    ser_dm_q,
  input  logic                          dm_slot,
  input  logic [STREAM_W+CHAN_W-1:0]    ser_cm_addr,
  output logic [7:0]                    ser_cm_low,
  output logic [CMH_W-1:0]              ser_cm_high,
  output logic                          msg_all
);
  import pp_pkg::*;

  localparam int DW       = 8;
  localparam int MEM_AW   = STREAM_W + CHAN_W;
  localparam int CR_SPLIT = 7;
  localparam int CR_MSG   = 6;
  localparam int CR_SPARE = 5;
  localparam int CR_SEL_H = 4;
  localparam int CR_SEL_L = 3;

  acc_state_e        state_q;
  win_sel_e          rd_src_q;
  win_sel_e          eff_sel;
  logic [DW-1:0]     ctrl_q;
  logic [DW-1:0]     ctrl_d;
  logic              stb_s;
  logic              go;
  logic              is_cr;
  logic              cml_we;
  logic              cmh_we;
  logic              dm_grant;
  logic [MEM_AW-1:0] win_addr;
  logic [MEM_AW-1:0] dm_raddr;
  logic [DW-1:0]     dm_q;
  logic [DW-1:0]     cml_a_q;
  logic [CMH_W-1:0]  cmh_a_q;
  logic [DW-1:0]     rd_mux;

  // strobe qualified by chip select, brought into clk domain
  pp_sync #(.W(1), .STAGES(SYNC_STG)) u_stb_sync (
    .clk (clk),
    .rst (rst),
    .d   (ds & ~cs_n),
    .q   (stb_s)
  );

  assign win_addr = {ctrl_q[STREAM_W-1:0], addr[CHAN_W-1:0]};
  assign is_cr    = ~addr[CHAN_W];
  assign go       = (state_q == ST_IDLE) && stb_s;

  always_comb begin
    if (ctrl_q[CR_SPLIT]) eff_sel = rw ? SEL_DM : SEL_CML;
    else                  eff_sel = win_sel_e'(ctrl_q[CR_SEL_H:CR_SEL_L]);
  end

  always_comb begin
    ctrl_d           = wdata;
    ctrl_d[CR_SPARE] = 1'b0;
  end

  assign cml_we   = go && !is_cr && !rw && (eff_sel == SEL_CML);
  assign cmh_we   = go && !is_cr && !rw && (eff_sel == SEL_CMH);
  assign dm_grant = (state_q == ST_DM_WAIT) && dm_slot;
  assign dm_raddr = dm_grant ? win_addr : ser_dm_raddr;
  assign ser_dm_q = dm_q;
  assign msg_all  = ctrl_q[CR_MSG];

  pp_sdp_ram #(.AW(MEM_AW), .DW(DW)) u_dm (
    .clk   (clk),
    .we    (ser_dm_we),
    .waddr (ser_dm_waddr),
    .wdata (ser_dm_wdata),
    .raddr (dm_raddr),
    .rq    (dm_q)
  );

  pp_tdp_ram #(.AW(MEM_AW), .DW(DW)) u_cml (
    .clk     (clk),
    .a_we    (cml_we),
    .a_addr  (win_addr),
    .a_wdata (wdata),
    .a_q     (cml_a_q),
    .b_addr  (ser_cm_addr),
    .b_q     (ser_cm_low)
  );

  pp_tdp_ram #(.AW(MEM_AW), .DW(CMH_W)) u_cmh (
    .clk     (clk),
    .a_we    (cmh_we),
    .a_addr  (win_addr),
    .a_wdata (wdata[CMH_W-1:0]),
    .a_q     (cmh_a_q),
    .b_addr  (ser_cm_addr),
    .b_q     (ser_cm_high)
  );

  always_comb begin
    case (rd_src_q)
      SEL_DM:  rd_mux = dm_q;
      SEL_CML: rd_mux = cml_a_q;
      SEL_CMH: rd_mux = {{(DW-CMH_W){1'b0}}, cmh_a_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      rd_src_q <= SEL_NONE;
      ctrl_q   <= '0;
      rdata    <= '0;
      rdata_en <= 1'b0;
      dta_n    <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (stb_s) begin
            if (is_cr) begin
              if (rw) begin
                rdata    <= ctrl_q;
                rdata_en <= 1'b1;
              end else begin
                ctrl_q <= ctrl_d;
              end
              dta_n   <= 1'b0;
              state_q <= ST_ACK;
            end else if (rw) begin
              case (eff_sel)
                SEL_DM:  state_q <= ST_DM_WAIT;
                SEL_CML, SEL_CMH: begin
                  rd_src_q <= eff_sel;
                  state_q  <= ST_RD;
                end
                default: begin
                  rdata    <= '0;
                  rdata_en <= 1'b1;
                  dta_n    <= 1'b0;
                  state_q  <= ST_ACK;
                end
              endcase
            end else begin
              dta_n   <= 1'b0;
              state_q <= ST_ACK;
            end
          end
        end
        ST_DM_WAIT: begin
          if (dm_slot) begin
            rd_src_q <= SEL_DM;
            state_q  <= ST_RD;
          end
        end
        ST_RD: begin
          rdata    <= rd_mux;
          rdata_en <= 1'b1;
          dta_n    <= 1'b0;
          state_q  <= ST_ACK;
        end
        default: begin
          if (!stb_s) begin
            dta_n    <= 1'b1;
            rdata_en <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // control register changes only after a synchronised control write
  assert_ctrl_write_only_R1: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q != $past(ctrl_q)) |-> $past(stb_s && !rw && !addr[CHAN_W]))
    else $error("control register changed without a control write");

  assert_spare_bit_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CR_SPARE])
    else $error("spare control bit set");

  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!dta_n && stb_s) |=> !dta_n)
    else $error("acknowledge dropped while strobe held");

  assert_ack_release_R7: assert property (@(posedge clk) disable iff (rst)
    (!dta_n && !stb_s) |=> dta_n)
    else $error("acknowledge not released after strobe");

  assert_no_slot_no_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DM_WAIT && !dm_slot) |=> dta_n)
    else $error("data memory read acknowledged without slot");

  assert_dm_read_granted_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD && rd_src_q == SEL_DM) |-> $past(dm_slot))
    else $error("data memory read without granted slot");

  assert_rden_in_ack_R11: assert property (@(posedge clk) disable iff (rst)
    rdata_en |-> !dta_n)
    else $error("read enable outside acknowledge");
endmodule

// File: tb/paged_cpu_port_tb.sv
module paged_cpu_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 200;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, ds = 1'b0, rw = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_en, dta_n;
  logic       ser_dm_we = 1'b0;
  logic [7:0] ser_dm_waddr = '0, ser_dm_wdata = '0, ser_dm_raddr = '0;
  logic [7:0] ser_dm_q;
  logic       dm_slot = 1'b1;
  logic [7:0] ser_cm_addr = '0;
  logic [7:0] ser_cm_low;
  logic [2:0] ser_cm_high;
  logic       msg_all;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_cpu_port dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ds(ds), .rw(rw), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en), .dta_n(dta_n),
    .ser_dm_we(ser_dm_we), .ser_dm_waddr(ser_dm_waddr),
    .ser_dm_wdata(ser_dm_wdata), .ser_dm_raddr(ser_dm_raddr),
    .ser_dm_q(ser_dm_q), .dm_slot(dm_slot), .ser_cm_addr(ser_cm_addr),
    .ser_cm_low(ser_cm_low), .ser_cm_high(ser_cm_high), .msg_all(msg_all)
  );

  function automatic logic [7:0] cml_val(input int idx);
    return 8'((idx * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] dm_val(input int idx);
    return 8'(idx) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL R7 watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // one bus transfer; checks ack timing (R7) and read enable (R11)
  task automatic bus(input logic is_rd, input logic [5:0] a, input logic [7:0] d,
                     input int max_lat, output logic [7:0] q);
    int lat;
    int rel;
    @(negedge clk);
    rw = is_rd; addr = a; wdata = d; cs_n = 1'b0;
    @(negedge clk);
    ds = 1'b1;
    lat = 0;
    while (dta_n && lat < LIMIT) begin @(negedge clk); lat++; end
    chk(!dta_n && lat <= max_lat, "R7 ack latency", lat, max_lat);
    q = rdata;
    chk(rdata_en == is_rd, "R11 rdata_en during ack", rdata_en, is_rd);
    ds = 1'b0;
    rel = 0;
    while (!dta_n && rel < LIMIT) begin @(negedge clk); rel++; end
    chk(dta_n && rel <= 4, "R7 ack release", rel, 4);
    chk(rdata_en == 1'b0, "R11 rdata_en after release", rdata_en, 0);
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] q;
    bus(1'b0, a, d, 6, q);
  endtask

  task automatic rd(input logic [5:0] a, input int max_lat, output logic [7:0] q);
    bus(1'b1, a, 8'h00, max_lat, q);
  endtask

  task automatic ser_cm_peek(input int idx, output logic [7:0] lo, output logic [2:0] hi);
    @(negedge clk);
    ser_cm_addr = 8'(idx);
    @(negedge clk);
    lo = ser_cm_low;
    hi = ser_cm_high;
  endtask

  initial begin
    logic [7:0] q;
    logic [7:0] lo;
    logic [2:0] hi;
    int lat;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(dta_n == 1'b1, "R10 dta_n reset", dta_n, 1);
    chk(rdata_en == 1'b0, "R10 rdata_en reset", rdata_en, 0);
    chk(msg_all == 1'b0, "R10 msg_all reset", msg_all, 0);
    rd(6'h00, 6, q);
    chk(q == 8'h00, "R10 control reset value", q, 0);

    // R1 control register aliasing, spare bit; R6 message bit
    wr(6'h00, 8'h7B);
    rd(6'h15, 6, q);
    chk(q == 8'h5B, "R1 control readback via alias", q, 8'h5B);
    chk(msg_all == 1'b1, "R6 msg_all set", msg_all, 1);
    wr(6'h1F, 8'h00);
    chk(msg_all == 1'b0, "R6 msg_all clear", msg_all, 0);
    rd(6'h0A, 6, q);
    chk(q == 8'h00, "R1 control cleared via alias", q, 0);

    // R2 low connection memory sweep
    for (int s = 0; s < 8; s++) begin
      wr(6'h00, 8'(8'h10 | s));
      for (int c = 0; c < 32; c++) wr(6'(6'h20 | c), cml_val(s * 32 + c));
    end
    for (int s = 0; s < 8; s++) begin
      wr(6'h00, 8'(8'h10 | s));
      for (int c = 0; c < 32; c++) begin
        rd(6'(6'h20 | c), 6, q);
        chk(q == cml_val(s * 32 + c), "R2 low connection readback", q, cml_val(s * 32 + c));
      end
    end

    // R3 high connection memory sweep
    for (int s = 0; s < 8; s++) begin
      wr(6'h00, 8'(8'h18 | s));
      for (int c = 0; c < 32; c++) wr(6'(6'h20 | c), 8'(8'hA8 ^ (s * 32 + c)));
    end
    for (int s = 0; s < 8; s++) begin
      wr(6'h00, 8'(8'h18 | s));
      for (int c = 0; c < 32; c++) begin
        rd(6'(6'h20 | c), 6, q);
        chk(q == 8'((s * 32 + c) & 7), "R3 high connection readback", q, (s * 32 + c) & 7);
      end
    end

    // R9 serial-side read of both connection memories
    for (int i = 0; i < 256; i++) begin
      ser_cm_peek(i, lo, hi);
      chk(lo == cml_val(i), "R9 serial low read", lo, cml_val(i));
      chk(hi == 3'(i & 7), "R9 serial high read", hi, i & 7);
    end

    // fill received-data memory from the serial side
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ser_dm_we = 1'b1; ser_dm_waddr = 8'(i); ser_dm_wdata = dm_val(i);
    end
    @(negedge clk);
    ser_dm_we = 1'b0;

    // R8 received-data reads with slot always free
    dm_slot = 1'b1;
    for (int s = 0; s < 8; s++) begin
      wr(6'h00, 8'(8'h08 | s));
      for (int c = 0; c < 32; c++) begin
        rd(6'(6'h20 | c), 12, q);
        chk(q == dm_val(s * 32 + c), "R8 data memory read", q, dm_val(s * 32 + c));
      end
    end

    // R4 write to data memory ignored
    wr(6'h00, 8'h0A);
    wr(6'h25, 8'hEE);
    rd(6'h25, 12, q);
    chk(q == dm_val(2 * 32 + 5), "R4 data memory write ignored", q, dm_val(69));

    // R4 reserved select: write ignored, read zero
    wr(6'h00, 8'h03);
    wr(6'h29, 8'h55);
    rd(6'h29, 6, q);
    chk(q == 8'h00, "R4 reserved select reads zero", q, 0);
    ser_cm_peek(3 * 32 + 9, lo, hi);
    chk(lo == cml_val(105), "R4 reserved write left low memory", lo, cml_val(105));
    chk(hi == 3'(105 & 7), "R4 reserved write left high memory", hi, 105 & 7);

    // R5 split mode: select says high memory, writes go low, reads from data
    wr(6'h00, 8'h9A);
    wr(6'h27, 8'hA5);
    rd(6'h27, 12, q);
    chk(q == dm_val(71), "R5 split read from data memory", q, dm_val(71));
    ser_cm_peek(71, lo, hi);
    chk(lo == 8'hA5, "R5 split write to low memory", lo, 8'hA5);
    chk(hi == 3'(71 & 7), "R5 split write left high memory", hi, 71 & 7);
    wr(6'h00, 8'h1A);
    rd(6'h27, 6, q);
    chk(q == 8'(71 & 7), "R5 split exit restores select", q, 71 & 7);

    // R8 slot withheld: no acknowledge until granted
    wr(6'h00, 8'h09);
    dm_slot = 1'b0;
    @(negedge clk);
    rw = 1'b1; addr = 6'h24; cs_n = 1'b0;
    @(negedge clk);
    ds = 1'b1;
    repeat (30) @(negedge clk);
    chk(dta_n == 1'b1, "R8 no ack without slot", dta_n, 1);
    dm_slot = 1'b1;
    lat = 0;
    while (dta_n && lat < LIMIT) begin @(negedge clk); lat++; end
    chk(!dta_n && lat <= 4, "R8 ack after slot grant", lat, 4);
    chk(rdata == dm_val(36), "R8 data after slot grant", rdata, dm_val(36));
    ds = 1'b0;
    lat = 0;
    while (!dta_n && lat < LIMIT) begin @(negedge clk); lat++; end
    chk(dta_n == 1'b1, "R7 release after slot read", dta_n, 1);
    @(negedge clk);
    cs_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule